// File: doc/BRIEF.md
# Power-On Reset and Startup Strap Sequencer

This block sits on the chipset side of a processor bus and controls processor reset at power-up. It watches an asynchronous power-good level from the supply and keeps the processor reset asserted while that level is low. After power-good rises, the block brings it into the clock domain through a two-stage synchronizer. It then holds reset for a parameterized settle interval so that the clock sources can stabilize.

For the whole time reset is asserted, the block drives a configuration word onto a set of shared strap lines. Software or firmware may load that word through a small write port while the sequence is still waiting for power or settling. At the start of a setup window the word is frozen. Reset is then released, so the receivers latch the straps on the trailing edge of reset. The straps stay driven for a hold window after release. The block then turns its drivers off and raises a ready indication.

Any loss of power-good immediately puts reset back to asserted, re-drives the straps, restores the configuration word to its default and starts the sequence again.

Top module: `porStrapSeq`

## Requirements
- R1: While pwrGoodAsync is low, cpuRstN is 0, strapOe is 1, sysReady is 0 and strapBus equals CFG_DEFAULT. A falling pwrGoodAsync forces these values at once, without waiting for a clock edge.
- R2: pwrGoodAsync passes through SYNC_STAGES (default 2) flip-flops. Reset then stays asserted for SETTLE_CYC further cycles.
- R3: Whenever cpuRstN is 0, strapOe is 1 and strapBus carries the stored configuration word.
- R4: With pwrGoodAsync raised between clock edges and edges numbered from 1 after that, cpuRstN first reads 1 after edge SETTLE_CYC+SETUP_CYC+4. The configuration word does not change during the SETUP_CYC+1 edges before release.
- R5: After release, strapOe stays 1 and strapBus stays unchanged for HOLD_CYC cycles. strapOe first reads 0 after edge SETTLE_CYC+SETUP_CYC+HOLD_CYC+4. Whenever strapOe is 0, strapBus is all zeros.
- R6: sysReady rises on the same edge on which strapOe falls, and it stays high until power-good is lost.
- R7: A write (cfgWrEn high at an edge) stores cfgWrData only up to and including edge SETTLE_CYC+3. Writes on later edges are ignored until the next power cycle.
- R8: After a power loss, the configuration word reads CFG_DEFAULT again, the full sequence repeats, and writes are accepted again inside the window of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| pwrGoodAsync | input | 1 | Asynchronous power-good from the supply; low means power not valid |
| cfgWrEn | input | 1 | Configuration word write strobe |
| cfgWrData | input | CFG_W | Configuration word write data |
| cpuRstN | output | 1 | Processor reset, active low |
| strapBus | output | CFG_W | Strap value on the shared lines, zero when not driven |
| strapOe | output | 1 | Strap driver enable; low means the lines are released |
| sysReady | output | 1 | High once the sequence has completed and the drivers are off |

## Verification
A wrong phase state or counter value shows up at the ports as a reset release, driver turn-off or ready rise on the wrong edge. Every output is therefore compared on every cycle of a full sequence against edge numbers computed from the three interval lengths. An error appears within one cycle of the edge where it happens. Corruption of the configuration register shows up on strapBus in the cycle after the bad write, because the straps are visible for the whole sequence up to the end of the hold window. Power is also removed at every cycle position of the sequence, so a missing asynchronous return to reset is caught in the same cycle.

// File: rtl/porSeqPkg.sv
package porSeqPkg;

  typedef enum logic [2:0] {
    ST_PWR_WAIT = 3'd0,
    ST_SETTLE   = 3'd1,
    ST_SETUP    = 3'd2,
    ST_HOLD     = 3'd3,
    ST_READY    = 3'd4
  } seqState_e;

  // Level strobes from control to datapath
  typedef struct packed {
    logic wrAllow;     // configuration word may be written
    logic rstRelease;  // processor reset may be deasserted
    logic drvOff;      // strap drivers may be released
  } seqStrb_t;

  function automatic int maxOf3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/porPgSync.sv
module porPgSync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic pgRaw,
  output logic pgStable
);

  logic [SYNC_STAGES-1:0] shReg;

  // Asynchronous clear on loss, synchronous pickup on rise
  always_ff @(posedge clk or negedge pgRaw) begin
    if (!pgRaw) shReg <= '0;
    else        shReg <= {shReg[SYNC_STAGES-2:0], 1'b1};
  end

  assign pgStable = shReg[SYNC_STAGES-1];

  // R2: once the synchronized level is up it stays up until power loss
  p_sync_hold_r2: assert property (@(posedge clk) disable iff (!pgRaw)
    pgStable |=> pgStable);

endmodule

// File: rtl/porSeqCtrl.sv
module porSeqCtrl
  import porSeqPkg::*;
#(
  parameter int SETTLE_CYC = 4,
  parameter int SETUP_CYC  = 3,
  parameter int HOLD_CYC   = 2
) (
  input  logic     clk,
  input  logic     pgRaw,
  input  logic     pgStable,
  output seqStrb_t strb
);

  localparam int MAX_CYC = maxOf3(SETTLE_CYC, SETUP_CYC, HOLD_CYC);
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] SETUP_LAST  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(HOLD_CYC - 1);

  seqState_e        state, stateNxt;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] phaseLast;
  logic             lastCyc;

  always_comb begin
    unique case (state)
      ST_SETTLE: phaseLast = SETTLE_LAST;
      ST_SETUP:  phaseLast = SETUP_LAST;
      ST_HOLD:   phaseLast = HOLD_LAST;
      default:   phaseLast = '0;
    endcase
  end

  assign lastCyc = (cnt == phaseLast);

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_PWR_WAIT: if (pgStable) stateNxt = ST_SETTLE;
      ST_SETTLE:   if (lastCyc)  stateNxt = ST_SETUP;
      ST_SETUP:    if (lastCyc)  stateNxt = ST_HOLD;
      ST_HOLD:     if (lastCyc)  stateNxt = ST_READY;
      ST_READY:    stateNxt = ST_READY;
      default:     stateNxt = ST_PWR_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge pgRaw) begin
    if (!pgRaw) begin
      state <= ST_PWR_WAIT;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      if (stateNxt != state || state == ST_READY || state == ST_PWR_WAIT)
        cnt <= '0;
      else
        cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    strb.wrAllow    = (state == ST_PWR_WAIT) || (state == ST_SETTLE);
    strb.rstRelease = (state == ST_HOLD) || (state == ST_READY);
    strb.drvOff     = (state == ST_READY);
  end

  // R2: sequence cannot start before synchronized power-good
  p_wait_sync_r2: assert property (@(posedge clk) disable iff (!pgRaw)
    !pgStable |-> state == ST_PWR_WAIT);

  // R2: settle phase lasts its full length
  p_settle_len_r2: assert property (@(posedge clk) disable iff (!pgRaw)
    (state == ST_SETUP && $past(state) == ST_SETTLE) |-> $past(cnt) == SETTLE_LAST);

  // R4: setup phase lasts its full length before release
  p_setup_len_r4: assert property (@(posedge clk) disable iff (!pgRaw)
    (state == ST_HOLD && $past(state) == ST_SETUP) |-> $past(cnt) == SETUP_LAST);

  // R5: hold phase lasts its full length before drivers turn off
  p_hold_len_r5: assert property (@(posedge clk) disable iff (!pgRaw)
    (state == ST_READY && $past(state) == ST_HOLD) |-> $past(cnt) == HOLD_LAST);

endmodule

// File: rtl/porSeqData.sv
module porSeqData
  import porSeqPkg::*;
#(
  parameter int               CFG_W       = 8,
  parameter logic [CFG_W-1:0] CFG_DEFAULT = '0
) (
  input  logic             clk,
  input  logic             pgRaw,
  input  seqStrb_t         strb,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic             cpuRstN,
  output logic [CFG_W-1:0] strapBus,
  output logic             strapOe,
  output logic             sysReady
);

  logic [CFG_W-1:0] cfgReg;
  logic             rstNReg;
  logic             oeReg;
  logic             readyReg;

  always_ff @(posedge clk or negedge pgRaw) begin
    if (!pgRaw)                       cfgReg <= CFG_DEFAULT;
    else if (cfgWrEn && strb.wrAllow) cfgReg <= cfgWrData;
  end

  always_ff @(posedge clk or negedge pgRaw) begin
    if (!pgRaw) begin
      rstNReg  <= 1'b0;
      oeReg    <= 1'b1;
      readyReg <= 1'b0;
    end else begin
      rstNReg  <= strb.rstRelease;
      oeReg    <= !strb.drvOff;
      readyReg <= strb.drvOff;
    end
  end

  assign cpuRstN  = rstNReg;
  assign strapOe  = oeReg;
  assign sysReady = readyReg;
  assign strapBus = oeReg ? cfgReg : '0;

  // R3: straps driven whenever reset is held
  p_drive_in_rst_r3: assert property (@(posedge clk) disable iff (!pgRaw)
    !cpuRstN |-> strapOe);

  // R4: straps valid and steady at the releasing edge
  p_straps_at_release_r4: assert property (@(posedge clk) disable iff (!pgRaw)
    $rose(cpuRstN) |-> strapOe && $stable(strapBus));

  // R7: no register change once writes are closed
  p_no_late_write_r7: assert property (@(posedge clk) disable iff (!pgRaw)
    !strb.wrAllow |=> $stable(cfgReg));

  // R6: ready only with drivers released
  p_ready_off_r6: assert property (@(posedge clk) disable iff (!pgRaw)
    sysReady |-> !strapOe && strapBus == '0 && cpuRstN);

endmodule

// File: rtl/porStrapSeq.sv
module porStrapSeq
  import porSeqPkg::*;
#(
  parameter int               CFG_W       = 8,
  parameter logic [CFG_W-1:0] CFG_DEFAULT = 8'hA5,
  parameter int               SYNC_STAGES = 2,
  parameter int               SETTLE_CYC  = 4,
  parameter int               SETUP_CYC   = 3,
  parameter int               HOLD_CYC    = 2
) (
  input  logic             clk,
  input  logic             pwrGoodAsync,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic             cpuRstN,
  output logic [CFG_W-1:0] strapBus,
  output logic             strapOe,
  output logic             sysReady
);

  logic     pgStable;
  seqStrb_t strb;

  porPgSync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk      (clk),
    .pgRaw    (pwrGoodAsync),
    .pgStable (pgStable)
  );

  porSeqCtrl #(
    .SETTLE_CYC (SETTLE_CYC),
    .SETUP_CYC  (SETUP_CYC),
    .HOLD_CYC   (HOLD_CYC)
  ) uCtrl (
    .clk      (clk),
    .pgRaw    (pwrGoodAsync),
    .pgStable (pgStable),
    .strb     (strb)
  );

  porSeqData #(
    .CFG_W       (CFG_W),
    .CFG_DEFAULT (CFG_DEFAULT)
  ) uData (
    .clk       (clk),
    .pgRaw     (pwrGoodAsync),
    .strb      (strb),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .cpuRstN   (cpuRstN),
    .strapBus  (strapBus),
    .strapOe   (strapOe),
    .sysReady  (sysReady)
  );

endmodule

// File: tb/tb_porStrapSeq.sv
module tb_porStrapSeq;

  localparam int          W   = 8;
  localparam int          S   = 4;
  localparam int          U   = 3;
  localparam int          H   = 2;
  localparam logic [W-1:0] DEF = 8'hA5;
  localparam int          REL = S + U + 4;
  localparam int          OFF = REL + H;

  logic         clk = 1'b0;
  logic         pg = 1'b0;
  logic         wrEn = 1'b0;
  logic [W-1:0] wrData = '0;
  logic         cpuRstN;
  logic [W-1:0] strapBus;
  logic         strapOe;
  logic         sysReady;

  always #2 clk = ~clk;

  porStrapSeq #(
    .CFG_W(W), .CFG_DEFAULT(DEF), .SYNC_STAGES(2),
    .SETTLE_CYC(S), .SETUP_CYC(U), .HOLD_CYC(H)
  ) dut (
    .clk(clk), .pwrGoodAsync(pg), .cfgWrEn(wrEn), .cfgWrData(wrData),
    .cpuRstN(cpuRstN), .strapBus(strapBus), .strapOe(strapOe), .sysReady(sysReady)
  );

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // R1: outputs in the powered-down state
  task automatic chkOff(input string tag);
    chk(cpuRstN == 1'b0, {tag, " R1 cpuRstN"}, int'(cpuRstN), 0);
    chk(strapOe == 1'b1, {tag, " R1 strapOe"}, int'(strapOe), 1);
    chk(sysReady == 1'b0, {tag, " R1 sysReady"}, int'(sysReady), 0);
    chk(strapBus == DEF, {tag, " R1 R8 strapBus default"}, int'(strapBus), int'(DEF));
  endtask

  task automatic powerDown();
    @(negedge clk);
    pg = 1'b0;
    #1;
    chkOff("powerDown");
    repeat (3) @(negedge clk);
  endtask

  // Full sequence, checked on every cycle
  task automatic runSeq(input bit doWr, input logic [W-1:0] goodVal,
                        input logic [W-1:0] lateVal);
    logic [W-1:0] expCfg;
    expCfg = DEF;
    @(negedge clk);
    pg = 1'b1;
    for (int k = 1; k <= OFF + 3; k++) begin
      wrEn   = doWr && (k == S + 3 || k == S + 4);
      wrData = (k == S + 3) ? goodVal : lateVal;
      @(posedge clk);
      @(negedge clk);
      if (doWr && k == S + 3) expCfg = goodVal;  // R7 last accepted edge
      chk(cpuRstN == (k >= REL), "R2 R4 release edge", int'(cpuRstN), int'(k >= REL));
      chk(strapOe == (k < OFF), "R3 R5 driver enable", int'(strapOe), int'(k < OFF));
      chk(sysReady == (k >= OFF), "R6 ready edge", int'(sysReady), int'(k >= OFF));
      chk(strapBus == ((k < OFF) ? expCfg : '0), "R3 R4 R5 R7 strap value",
          int'(strapBus), int'((k < OFF) ? expCfg : '0));
    end
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chkOff("initial");

    runSeq(1'b0, '0, '0);
    powerDown();
    runSeq(1'b1, 8'h3C, 8'hC3);
    powerDown();                 // R8: default restored after writes
    runSeq(1'b1, 8'h5A, 8'hFF);  // R8: writes accepted again
    powerDown();

    // R1: loss of power at every position in the sequence
    for (int d = 0; d <= OFF + 2; d++) begin
      @(negedge clk);
      pg = 1'b1;
      repeat (d) @(negedge clk);
      #1;
      pg = 1'b0;
      #0.5;
      chkOff("sweep");
      repeat (3) @(negedge clk);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

endmodule